// File: doc/BRIEF.md
# Multi-Path Source-Routed Slot Scheduler

This block is the transmit half of a network interface that injects guaranteed-throughput traffic with source routing. A repeating slot counter walks a slot table. Each table entry names the channel that owns the slot and a small route identifier. A separate bank per channel turns the identifier into a full route, so one channel can spread its traffic over several paths. Storage grows with the number of distinct routes, not with the number of slots.

Each slot lasts three output words. At the start of a slot the block decides whether the owning channel continues the flit sequence of the slot before. If it does not, the first word of the slot is a header that carries the channel number and the whole route. The payload words are popped from that channel's input queue in order. Both tables are written through one address/data/strobe port while the block is disabled. Enabling the block restarts the slot walk at slot 0.

Top module: `mpath_tx_sched`

## Requirements
- R1: While `rst` is high, or while `en` was low at a clock edge, the output after that edge has `out_valid`=0 and `out_hdr`=0, and `q_pop` is all zero.
- R2: Slot processing restarts at slot 0, word 0 on the first edge with `en` high. The word for that position appears on the outputs directly after that edge. Slots then follow in increasing order and wrap from the last slot to slot 0.
- R3: A header word has the channel number in bits [31:30] and the 30-bit route in bits [29:0]. The route holds 3-bit output-port selectors with the first hop in bits [2:0] and zeros above the last hop. `out_hdr`=1 and `out_chan` give the channel.
- R4: A header is sent at the start of a used slot when the previous slot was unused, belonged to another channel, or had another route id. It is also sent on the first slot after enabling. This covers the wrap from the last slot to slot 0.
- R5: When a used slot follows a fully used slot with the same channel and route id, no header is sent. This holds across the wrap as well.
- R6: A slot is 3 words long. A header may only occupy word 0, which leaves 2 payload words in that slot.
- R7: Payload words leave in the order of their channel's queue. `q_pop` has one bit set for each word emitted, and `out_chan` names the channel.
- R8: A slot whose channel queue is empty at word 0 is idle for all 3 words. A queue that runs empty inside a slot makes the rest of that slot idle. In both cases the channel's next used slot starts with a header.
- R9: A slot table entry whose valid bit is 0 produces an idle slot.
- R10: Table writes are ignored while `en` is high.
- R11: The header route is the entry at (channel, route id) of the route banks. A slot table write to `cfg_tbl`=0 uses address bits [2:0] as the slot number and data bit 4 as valid, [3:2] as channel and [1:0] as route id. A route write to `cfg_tbl`=1 uses address [3:2] as channel, [1:0] as route id and data [29:0] as the route.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low allows table writes and parks the slot walk at 0 |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | Table select: 0 slot table, 1 route banks |
| cfg_addr | input | 4 | Slot number, or {channel, route id} |
| cfg_wdata | input | 30 | Slot entry or route |
| q_valid | input | 4 | Per-channel queue holds a word |
| q_data | input | 128 | Per-channel queue head words, channel c at bits [32c+31:32c] |
| q_pop | output | 4 | Pops the head of a channel queue at this edge |
| out_valid | output | 1 | Output word is valid |
| out_hdr | output | 1 | Output word is a route header |
| out_chan | output | 2 | Channel of the output word |
| out_data | output | 32 | Output word |

## Verification
A corrupted slot or word counter shows up within one slot as a header outside word 0, or as payload from the wrong channel. A stale continuity record shows at the next used slot of the channel: a header appears where none belongs, or a needed one is missing, and the payload then moves by one word. A wrong route-bank index shows in the first header of the affected slot. A missed or doubled pop shifts every later payload word of that channel. The per-cycle comparison therefore catches each of these within three cycles of the first slot it affects.

// File: rtl/mpath_pkg.sv
package mpath_pkg;

    localparam int NCH     = 4;
    localparam int NRT     = 4;
    localparam int NSLOT   = 8;
    localparam int WPS     = 3;
    localparam int DW      = 32;

    localparam int CH_W    = $clog2(NCH);
    localparam int RID_W   = $clog2(NRT);
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int WC_W    = $clog2(WPS);
    localparam int ROUTE_W = DW - CH_W;
    localparam int ENT_W   = 1 + CH_W + RID_W;
    localparam int CFG_AW  = (SLOT_W > CH_W + RID_W) ? SLOT_W : CH_W + RID_W;

    typedef struct packed {
        logic             vld;
        logic [CH_W-1:0]  ch;
        logic [RID_W-1:0] rid;
    } slot_ent_t;

    function automatic logic [DW-1:0] make_header(
        input logic [CH_W-1:0]    ch,
        input logic [ROUTE_W-1:0] route
    );
        return {ch, route};
    endfunction

endpackage

// File: rtl/mpath_slot_table.sv
module mpath_slot_table
    import mpath_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  slot_ent_t         wr_ent,
    input  logic [SLOT_W-1:0] rd_idx,
    output slot_ent_t         rd_ent
);

    slot_ent_t tab [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) tab[i] <= '0;
        end else if (wr_en) begin
            tab[wr_idx] <= wr_ent;
        end
    end

    assign rd_ent = tab[rd_idx];

endmodule

// File: rtl/mpath_route_store.sv
module mpath_route_store
    import mpath_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_ch,
    input  logic [RID_W-1:0]   wr_rid,
    input  logic [ROUTE_W-1:0] wr_route,
    input  logic [CH_W-1:0]    rd_ch,
    input  logic [RID_W-1:0]   rd_rid,
    output logic [ROUTE_W-1:0] rd_route
);

    logic [ROUTE_W-1:0] per_ch [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_bank
        logic [ROUTE_W-1:0] bank [NRT];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int r = 0; r < NRT; r++) bank[r] <= '0;
            end else if (wr_en && wr_ch == CH_W'(c)) begin
                bank[wr_rid] <= wr_route;
            end
        end

        assign per_ch[c] = bank[rd_rid];
    end

    assign rd_route = per_ch[rd_ch];

endmodule

// File: rtl/mpath_cont_track.sv
module mpath_cont_track
    import mpath_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      slot_start,
    input  logic      use_now,
    input  logic      dry,
    input  slot_ent_t ent,
    output logic      need_hdr
);

    logic             cv_q;
    logic [CH_W-1:0]  cc_q;
    logic [RID_W-1:0] cr_q;

    assign need_hdr = !(cv_q && cc_q == ent.ch && cr_q == ent.rid);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cv_q <= 1'b0;
            cc_q <= '0;
            cr_q <= '0;
        end else if (slot_start) begin
            cv_q <= use_now;
            cc_q <= ent.ch;
            cr_q <= ent.rid;
        end else if (dry) begin
            cv_q <= 1'b0;
        end
    end

    // R8: a starved word forces a header on the channel's next sequence
    p_dry_breaks_r8: assert property (@(posedge clk) disable iff (rst)
        dry |=> need_hdr);

    // R4: after a disabled cycle every slot start asks for a header
    p_off_forces_hdr_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> need_hdr);

endmodule

// File: rtl/mpath_tx_sched.sv
module mpath_tx_sched
    import mpath_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               cfg_we,
    input  logic               cfg_tbl,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [ROUTE_W-1:0] cfg_wdata,
    input  logic [NCH-1:0]     q_valid,
    input  logic [NCH*DW-1:0]  q_data,
    output logic [NCH-1:0]     q_pop,
    output logic               out_valid,
    output logic               out_hdr,
    output logic [CH_W-1:0]    out_chan,
    output logic [DW-1:0]      out_data
);

    logic [SLOT_W-1:0]  slot_q;
    logic [WC_W-1:0]    wcnt_q;
    logic               cur_use_q;
    logic [CH_W-1:0]    cur_ch_q;

    slot_ent_t          ent;
    slot_ent_t          wr_ent;
    logic [ROUTE_W-1:0] route;
    logic               need_hdr;
    logic               slot_start;
    logic               start_use;
    logic               emit_hdr;
    logic               emit_data;
    logic               dry;
    logic [CH_W-1:0]    ch_now;
    logic [DW-1:0]      word_now;

    assign wr_ent = slot_ent_t'(cfg_wdata[ENT_W-1:0]);

    mpath_slot_table u_slots (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we && !en && !cfg_tbl),
        .wr_idx (cfg_addr[SLOT_W-1:0]),
        .wr_ent (wr_ent),
        .rd_idx (slot_q),
        .rd_ent (ent)
    );

    mpath_route_store u_routes (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we && !en && cfg_tbl),
        .wr_ch    (cfg_addr[CH_W+RID_W-1:RID_W]),
        .wr_rid   (cfg_addr[RID_W-1:0]),
        .wr_route (cfg_wdata),
        .rd_ch    (ent.ch),
        .rd_rid   (ent.rid),
        .rd_route (route)
    );

    mpath_cont_track u_cont (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .slot_start (slot_start),
        .use_now    (start_use),
        .dry        (dry),
        .ent        (ent),
        .need_hdr   (need_hdr)
    );

    assign slot_start = (wcnt_q == '0);
    assign start_use  = ent.vld && q_valid[ent.ch];
    assign ch_now     = slot_start ? ent.ch : cur_ch_q;
    assign word_now   = q_data[ch_now*DW +: DW];

    assign emit_hdr  = en && slot_start && start_use && need_hdr;
    assign emit_data = en && (slot_start ? (start_use && !need_hdr)
                                         : (cur_use_q && q_valid[cur_ch_q]));
    assign dry       = en && !slot_start && cur_use_q && !q_valid[cur_ch_q];
    assign q_pop     = emit_data ? (NCH'(1) << ch_now) : '0;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            slot_q    <= '0;
            wcnt_q    <= '0;
            cur_use_q <= 1'b0;
            cur_ch_q  <= '0;
            out_valid <= 1'b0;
            out_hdr   <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            if (wcnt_q == WC_W'(WPS - 1)) begin
                wcnt_q <= '0;
                slot_q <= (slot_q == SLOT_W'(NSLOT - 1)) ? '0 : slot_q + 1'b1;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
            end
            if (slot_start) begin
                cur_use_q <= start_use;
                cur_ch_q  <= ent.ch;
            end
            out_valid <= emit_hdr || emit_data;
            out_hdr   <= emit_hdr;
            out_chan  <= (emit_hdr || emit_data) ? ch_now : '0;
            out_data  <= emit_hdr  ? make_header(ent.ch, route) :
                         emit_data ? word_now : '0;
        end
    end

    // R1: a disabled cycle yields an idle output
    p_off_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!out_valid && !out_hdr));

    // R7: at most one queue is popped per word
    p_pop_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_pop));

    // R8: no pop from a queue that holds nothing
    p_pop_has_word_r8: assert property (@(posedge clk) disable iff (rst)
        (q_pop & ~q_valid) == '0);

    // R6: a header always sits in word 0 of its slot
    p_hdr_word0_r6: assert property (@(posedge clk) disable iff (rst)
        out_hdr |-> (wcnt_q == WC_W'(1)));

    // R3: a header is always a valid word
    p_hdr_valid_r3: assert property (@(posedge clk) disable iff (rst)
        out_hdr |-> out_valid);

endmodule

// File: tb/mpath_tx_sched_tb_top.sv
`timescale 1ns/1ps
module mpath_tx_sched_tb_top;

    localparam realtime CLK_NS = 8.0;

    logic         clk = 1'b0;
    logic         rst;
    logic         en;
    logic         cfg_we;
    logic         cfg_tbl;
    logic [3:0]   cfg_addr;
    logic [29:0]  cfg_wdata;
    logic [3:0]   q_valid;
    logic [127:0] q_data;
    logic [3:0]   q_pop;
    logic         out_valid;
    logic         out_hdr;
    logic [1:0]   out_chan;
    logic [31:0]  out_data;

    always #(CLK_NS / 2.0) clk = ~clk;

    mpath_tx_sched dut_i (
        .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .q_valid(q_valid),
        .q_data(q_data), .q_pop(q_pop), .out_valid(out_valid),
        .out_hdr(out_hdr), .out_chan(out_chan), .out_data(out_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 0;

    // queues seen by the design, and the model's own copies
    logic [31:0] bq [4][$];
    logic [31:0] mq [4][$];

    // model tables and state
    bit          m_sv [8];
    int          m_sc [8];
    int          m_sr [8];
    logic [29:0] m_rt [4][4];
    int          m_slot, m_w, m_cur_ch, m_cc, m_cr;
    bit          m_cur_use, m_cont;
    bit          e_valid, e_hdr;
    logic [1:0]  e_chan;
    logic [31:0] e_data;

    // directed observation counters
    int          hdr_cnt;
    int          dat_cnt [4];
    logic [31:0] hv [8];
    logic [31:0] last_d [4];
    bit          have_d [4];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic refresh_q();
        for (int c = 0; c < 4; c++) begin
            q_valid[c]         = bq[c].size() > 0;
            q_data[c*32 +: 32] = (bq[c].size() > 0) ? bq[c][0] : 32'h0;
        end
    endtask

    task automatic push(input int c, input logic [31:0] v);
        bq[c].push_back(v);
        mq[c].push_back(v);
        refresh_q();
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clear_obs();
        hdr_cnt = 0;
        for (int c = 0; c < 4; c++) begin
            dat_cnt[c] = 0;
            have_d[c]  = 0;
        end
    endtask

    task automatic cfg_wr(input bit tbl, input int addr, input logic [29:0] d);
        cfg_we = 1; cfg_tbl = tbl; cfg_addr = addr[3:0]; cfg_wdata = d;
        if (!en) begin
            if (!tbl) begin
                m_sv[addr[2:0]] = d[4];
                m_sc[addr[2:0]] = int'(d[3:2]);
                m_sr[addr[2:0]] = int'(d[1:0]);
            end else begin
                m_rt[addr[3:2]][addr[1:0]] = d;
            end
        end
        @(negedge clk);
        cfg_we = 0;
    endtask

    function automatic logic [29:0] sent(input bit v, input int c, input int r);
        return {25'd0, v, c[1:0], r[1:0]};
    endfunction

    // pop the design-side queues from the pops it requested at this edge
    always @(posedge clk) begin
        logic [3:0] p;
        p = q_pop;
        #1;
        for (int c = 0; c < 4; c++)
            if (p[c] && bq[c].size() > 0) void'(bq[c].pop_front());
        refresh_q();
    end

    // behavioural reference: one output word per enabled clock
    always @(posedge clk) begin
        bit st, nh;
        int c, r;
        if (rst || !en) begin
            m_slot = 0; m_w = 0; m_cur_use = 0; m_cont = 0;
            e_valid = 0; e_hdr = 0; e_chan = 0; e_data = 0;
        end else begin
            e_valid = 0; e_hdr = 0; e_chan = 0; e_data = 0;
            if (m_w == 0) begin
                c  = m_sc[m_slot];
                r  = m_sr[m_slot];
                st = m_sv[m_slot] && mq[c].size() > 0;
                nh = !(m_cont && m_cc == c && m_cr == r);
                m_cur_use = st; m_cur_ch = c;
                m_cont = st; m_cc = c; m_cr = r;
                if (st) begin
                    e_valid = 1; e_chan = c[1:0];
                    if (nh) begin
                        e_hdr = 1; e_data = {c[1:0], m_rt[c][r]};
                    end else begin
                        e_data = mq[c].pop_front();
                    end
                end
            end else if (m_cur_use && mq[m_cur_ch].size() > 0) begin
                e_valid = 1; e_chan = m_cur_ch[1:0];
                e_data = mq[m_cur_ch].pop_front();
            end else if (m_cur_use) begin
                m_cont = 0;
            end
            if (m_w == 2) begin
                m_w = 0;
                m_slot = (m_slot == 7) ? 0 : m_slot + 1;
            end else begin
                m_w++;
            end
        end
    end

    // per-cycle comparison and directed observation
    always @(negedge clk) begin
        if (chk_on) begin
            string rq;
            rq = e_hdr ? "R3" : (e_valid ? "R7" : "R8");
            chk({out_valid, out_hdr, out_chan} == {e_valid, e_hdr, e_chan}, rq,
                "flags v/h/chan", {28'd0, out_valid, out_hdr, out_chan},
                {28'd0, e_valid, e_hdr, e_chan});
            chk(out_data == e_data, rq, "word", out_data, e_data);
            if (out_valid && out_hdr) begin
                if (hdr_cnt < 8) hv[hdr_cnt] = out_data;
                hdr_cnt++;
            end else if (out_valid) begin
                if (have_d[out_chan])
                    chk(out_data == last_d[out_chan] + 1, "R7", "payload order",
                        out_data, last_d[out_chan] + 1);
                last_d[out_chan] = out_data;
                have_d[out_chan] = 1;
                dat_cnt[out_chan]++;
            end
        end
    end

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1; en = 0; cfg_we = 0; cfg_tbl = 0; cfg_addr = 0; cfg_wdata = 0;
        for (int i = 0; i < 8; i++) begin m_sv[i] = 0; m_sc[i] = 0; m_sr[i] = 0; end
        for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) m_rt[i][j] = '0;
        refresh_q();
        clear_obs();
        run(3);
        // R1: reset state
        chk(!out_valid && !out_hdr, "R1", "reset valid/hdr", {30'd0, out_valid, out_hdr}, 0);
        chk(out_data == 0, "R1", "reset data", out_data, 0);
        chk(q_pop == 0, "R1", "reset pop", {28'd0, q_pop}, 0);
        rst = 0;
        run(1);
        chk_on = 1;

        // Phase A: one channel, two routes in alternating slot groups
        cfg_wr(0, 0, sent(1, 1, 0)); cfg_wr(0, 1, sent(1, 1, 0));
        cfg_wr(0, 2, sent(1, 1, 1)); cfg_wr(0, 3, sent(1, 1, 1));
        cfg_wr(0, 4, sent(1, 1, 0)); cfg_wr(0, 5, sent(1, 1, 0));
        cfg_wr(0, 6, sent(1, 2, 2)); cfg_wr(0, 7, sent(0, 3, 3));
        cfg_wr(1, 4*1 + 0, 30'd209);   // hops 1,2,3
        cfg_wr(1, 4*1 + 1, 30'd4012);  // hops 4,5,6,7
        cfg_wr(1, 4*1 + 2, 30'd777);
        cfg_wr(1, 4*2 + 2, 30'd2);
        cfg_wr(1, 4*2 + 0, 30'd999);
        #1;
        for (int i = 0; i < 60; i++) push(1, 32'h1000 + i);
        clear_obs();
        en = 1;
        run(1);
        chk(out_hdr && out_data == 32'h4000_00D1, "R2", "first word is slot 0 header",
            out_data, 32'h4000_00D1);
        run(47);
        chk(hdr_cnt == 6, "R4", "headers in two revolutions", hdr_cnt, 6);
        chk(hv[1] == 32'h4000_0FAC, "R11", "second route header", hv[1], 32'h4000_0FAC);
        chk(hv[2] == 32'h4000_00D1, "R3", "route switch back header", hv[2], 32'h4000_00D1);
        chk(dat_cnt[1] == 30, "R6", "payload words per two revolutions", dat_cnt[1], 30);
        chk(dat_cnt[2] == 0, "R8", "empty channel stays idle", dat_cnt[2], 0);

        // Phase B: single word on channel 2 -> header, one word, starved word
        clear_obs();
        push(2, 32'h2000);
        run(24);
        chk(hdr_cnt == 4, "R4", "headers with channel 2 active", hdr_cnt, 4);
        chk(hv[3] == 32'h8000_0002, "R3", "channel 2 header", hv[3], 32'h8000_0002);
        chk(dat_cnt[2] == 1, "R8", "channel 2 payload", dat_cnt[2], 1);

        // Phase C: whole table on one channel and route; wrap keeps continuity
        en = 0;
        run(1);
        chk(!out_valid && q_pop == 0, "R1", "disabled output idle", {31'd0, out_valid}, 0);
        for (int s = 0; s < 8; s++) cfg_wr(0, s, sent(1, 0, 1));
        cfg_wr(1, 1, 30'd5);
        cfg_wr(1, 0, 30'd9);
        #1;
        for (int i = 0; i < 60; i++) push(0, 32'h3000 + i);
        clear_obs();
        en = 1;
        run(48);
        chk(hdr_cnt == 1, "R5", "single header across wrap", hdr_cnt, 1);
        chk(hv[0] == 32'h0000_0005, "R11", "channel 0 route 1 header", hv[0], 5);
        chk(dat_cnt[0] == 47, "R5", "payload words across wrap", dat_cnt[0], 47);

        // Phase D: write while enabled must not take effect
        for (int i = 60; i < 90; i++) push(0, 32'h3000 + i);
        clear_obs();
        cfg_wr(0, 3, sent(0, 0, 0));
        #1;
        run(23);
        chk(hdr_cnt == 0, "R10", "no header after ignored write", hdr_cnt, 0);
        chk(dat_cnt[0] == 24, "R10", "slot 3 still used", dat_cnt[0], 24);

        // Phase E: queue empties between slots, refill needs a new header
        en = 0;
        run(1);
        for (int s = 0; s < 8; s++) cfg_wr(0, s, sent(1, 3, 0));
        cfg_wr(1, 4*3 + 0, 30'h3FFF_FFFF);
        #1;
        for (int i = 0; i < 4; i++) push(3, 32'h4000 + i);
        clear_obs();
        en = 1;
        run(12);
        for (int i = 4; i < 6; i++) push(3, 32'h4000 + i);
        run(12);
        chk(hdr_cnt == 2, "R8", "header after starved slots", hdr_cnt, 2);
        chk(hv[1] == 32'hFFFF_FFFF, "R3", "full-width route header", hv[1], 32'hFFFF_FFFF);
        chk(dat_cnt[3] == 6, "R8", "channel 3 payload", dat_cnt[3], 6);

        // Phase F: invalid entries give idle slots
        en = 0;
        run(1);
        for (int s = 0; s < 8; s++) cfg_wr(0, s, sent(0, 0, 1));
        #1;
        clear_obs();
        en = 1;
        run(24);
        chk(hdr_cnt == 0 && dat_cnt[0] == 0, "R9", "invalid entries idle",
            hdr_cnt + dat_cnt[0], 0);

        chk_on = 0;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule